// File: doc/BRIEF.md
# Four-Channel Counter/Timer

The block holds four independent down-counting channels behind a byte-wide register port. Each channel has one address. A channel runs either as a timer, which counts the system clock after a prescaler of 16 or 256, or as a counter, which counts one chosen edge of its own external trigger input. Software programs a channel by writing a control byte. When that byte asks for it, software then writes a time constant. The channel starts only once the time constant arrives.

Every time a channel's count runs out, the channel reloads its time constant, gives a one-clock pulse on its zero-count output and, if interrupts are enabled for it, raises a pending request. A fixed priority chain places channel 0 first and picks one pending channel. An acknowledge pulse retires that channel's request. The interrupt vector carries a software-written base together with the winning channel's number.

Top module: `quad_ctc`

## Requirements
- R1: After reset every channel is stopped with a count of 0, all zero-count outputs and `irq` are low, and `int_vec` is 0.
- R2: A written byte with bit 0 = 1 is a control byte: bit 7 enables interrupts, bit 6 selects counter mode (1) or timer mode (0), bit 5 selects a prescale of 256 (1) or 16 (0), bit 4 selects the rising (1) or falling (0) trigger edge, bit 2 announces that a time constant follows, and bit 1 stops the channel. A byte with bit 0 = 0 written to channel 0 sets the vector base (bits 7:3). The same byte written to any other channel has no effect on the vector.
- R3: A channel does not count until it has received a time constant, however long it waits.
- R4: After a control byte with bit 2 set, the next write to that channel loads the time constant into both the reload register and the count, whatever its bit 0, and starts the channel.
- R5: In timer mode the count decrements once every 16 or 256 clocks, measured from the clock edge that loads the time constant.
- R6: In counter mode the count decrements once per selected edge of that channel's `ext_clk` bit. The other edge is ignored.
- R7: A time constant of 0 yields 256 decrements between zero-count events.
- R8: On terminal count the channel reloads the time constant and drives its `zc` bit high for exactly one clock.
- R9: A terminal count raises the channel's interrupt request only if bit 7 of its control byte is set. `irq` is high while any request is pending.
- R10: A control byte with bit 1 set stops the channel. Its count then holds and no zero-count pulses occur.
- R11: Channel 0 has the highest priority and channel 3 the lowest. `int_vec` is {base, winning channel number in bits 2:1, 0}, and `int_ack` clears the winner's request.
- R12: `rdata` returns the current count of the channel selected by `addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one byte |
| addr | input | 2 | Channel select for writes and reads |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Current count of the addressed channel |
| ext_clk | input | 4 | External count/trigger input, one bit per channel |
| zc | output | 4 | One-clock zero-count pulse, one bit per channel |
| irq | output | 1 | Any channel's interrupt pending |
| int_ack | input | 1 | Interrupt acknowledge pulse |
| int_vec | output | 8 | Vector of the highest-priority pending channel |

## Verification
The assertions assume that external trigger inputs change no faster than every other clock. In counter mode with a time constant of 1, this keeps zero-count pulses apart. The bench holds each `ext_clk` level for four clocks. The assertions also assume that a time-constant write and a terminal count in the same clock resolve in favour of the write. The bench only writes to channels that are stopped, so it never depends on that case. The exact-cycle checks on `zc` assume the timer starts from the time-constant write edge. The bench samples on the falling edge and counts whole clock periods from the write.

// File: rtl/ctc_pkg.sv
// Shared control-byte bit positions for the counter/timer block.
// Assumes an 8-bit write byte; bit 0 tells control bytes from vectors.
package ctc_pkg;
    localparam int CB_CTRL = 0;  // 1: control byte, 0: vector
    localparam int CB_STOP = 1;  // stop channel
    localparam int CB_TCF  = 2;  // time constant follows
    localparam int CB_EDGE = 4;  // 1: rising edge, 0: falling edge
    localparam int CB_PSEL = 5;  // 1: prescale long, 0: short
    localparam int CB_MODE = 6;  // 1: counter, 0: timer
    localparam int CB_IE   = 7;  // interrupt enable
endpackage

// File: rtl/ctc_chan.sv
// One counter/timer channel: decodes writes, prescales or edge-detects,
// counts down, reloads on terminal count and holds its own request.
// Assumes wr_sel is a single-cycle qualified write to this channel and
// ext_in is asynchronous (it is synchronised here).
module ctc_chan
    import ctc_pkg::*;
#(
    parameter int DW    = 8,
    parameter int PS_LO = 16,
    parameter int PS_HI = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_sel,
    input  logic [DW-1:0] wdata,
    input  logic          ext_in,
    input  logic          ack_clr,
    output logic [DW-1:0] cnt_o,
    output logic          zc_o,
    output logic          pend_o,
    output logic          vec_wr_o
);
    localparam int PSW = $clog2(PS_HI);

    logic [DW-1:0]  ctrl_q;
    logic [DW-1:0]  tc_q;
    logic [DW-1:0]  cnt_q;
    logic [PSW-1:0] ps_q;
    logic           tcf_q;
    logic           run_q;
    logic [1:0]     sync_q;
    logic           prev_q;
    logic           zc_q;
    logic           pend_q;

    logic           tc_wr;
    logic           ctl_wr;
    logic [PSW-1:0] ps_lim;
    logic           ps_wrap;
    logic           tick;
    logic           term;
    logic           edge_hit;

    // Classify a write: time constant, control byte or vector.
    always_comb begin
        tc_wr    = wr_sel && tcf_q;
        ctl_wr   = wr_sel && !tcf_q && wdata[CB_CTRL];
        vec_wr_o = wr_sel && !tcf_q && !wdata[CB_CTRL];
    end

    // Select the prescale limit and build the count tick.
    always_comb begin
        ps_lim   = ctrl_q[CB_PSEL] ? PSW'(PS_HI - 1) : PSW'(PS_LO - 1);
        ps_wrap  = (ps_q >= ps_lim);
        edge_hit = ctrl_q[CB_EDGE] ? (sync_q[1] && !prev_q) : (!sync_q[1] && prev_q);
        tick     = run_q && (ctrl_q[CB_MODE] ? edge_hit : ps_wrap);
        term     = tick && (cnt_q == DW'(1));
    end

    // Synchronise the external trigger and keep its previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], ext_in};
            prev_q <= sync_q[1];
        end
    end

    // Hold the control byte and the time-constant-follows flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            tcf_q  <= 1'b0;
        end else if (ctl_wr) begin
            ctrl_q <= wdata;
            tcf_q  <= wdata[CB_TCF];
        end else if (tc_wr) begin
            tcf_q  <= 1'b0;
        end
    end

    // Run flag: set by a time constant, cleared by a stop control byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else if (tc_wr) begin
            run_q <= 1'b1;
        end else if (ctl_wr && wdata[CB_STOP]) begin
            run_q <= 1'b0;
        end
    end

    // Prescaler: free-runs in timer mode while running, restarts on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else if (!run_q || ctrl_q[CB_MODE] || tc_wr || ps_wrap) begin
            ps_q <= '0;
        end else begin
            ps_q <= ps_q + PSW'(1);
        end
    end

    // Time constant and down-counter with automatic reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_q  <= '0;
            cnt_q <= '0;
        end else if (tc_wr) begin
            tc_q  <= wdata;
            cnt_q <= wdata;
        end else if (term) begin
            cnt_q <= tc_q;
        end else if (tick) begin
            cnt_q <= cnt_q - DW'(1);
        end
    end

    // Zero-count pulse and interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zc_q   <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            zc_q <= term && !tc_wr;
            if (term && !tc_wr && ctrl_q[CB_IE]) begin
                pend_q <= 1'b1;
            end else if (ack_clr) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign cnt_o  = cnt_q;
    assign zc_o   = zc_q;
    assign pend_o = pend_q;

    AST_ZC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        zc_q |=> !zc_q); // R8
    AST_ZC_RELOADED: assert property (@(posedge clk) disable iff (!rst_n)
        zc_q |-> (cnt_q == tc_q)); // R8
    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !wr_sel) |=> $stable(cnt_q)); // R10
    AST_PEND_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(ctrl_q[CB_IE])); // R9
endmodule

// File: rtl/ctc_prio.sv
// Fixed-priority daisy chain: index 0 wins, each stage passes enable on
// only when it has nothing pending. Produces a one-hot grant and index.
module ctc_prio #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  pend,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx,
    output logic          any
);
    logic [N:0] ena;

    assign ena[0] = 1'b1;

    // One chain stage per channel.
    generate
        for (genvar i = 0; i < N; i++) begin : g_stage
            assign grant[i]  = ena[i] && pend[i];
            assign ena[i+1]  = ena[i] && !pend[i];
        end
    endgenerate

    // Encode the granted stage into a channel number.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = IW'(i);
        end
    end

    assign any = !ena[N];

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R11
endmodule

// File: rtl/quad_ctc.sv
// Four-channel counter/timer top: address decode, read mux, vector base
// register (written through channel 0) and the priority chain.
// Assumes one write per cycle and a single-cycle int_ack pulse.
module quad_ctc
    import ctc_pkg::*;
#(
    parameter int N_CH  = 4,
    parameter int DW    = 8,
    parameter int PS_LO = 16,
    parameter int PS_HI = 256
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [$clog2(N_CH)-1:0] addr,
    input  logic [DW-1:0]           wdata,
    output logic [DW-1:0]           rdata,
    input  logic [N_CH-1:0]         ext_clk,
    output logic [N_CH-1:0]         zc,
    output logic                    irq,
    input  logic                    int_ack,
    output logic [DW-1:0]           int_vec
);
    localparam int AW = $clog2(N_CH);
    localparam int BW = DW - AW - 1;

    logic [DW-1:0]   cnt   [N_CH];
    logic [N_CH-1:0] pend;
    logic [N_CH-1:0] grant;
    logic [N_CH-1:0] vec_wr;
    logic [AW-1:0]   win_idx;
    logic            any_pend;
    logic [BW-1:0]   base_q;

    // One channel instance per address.
    generate
        for (genvar i = 0; i < N_CH; i++) begin : g_ch
            ctc_chan #(.DW(DW), .PS_LO(PS_LO), .PS_HI(PS_HI)) u_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_sel   (wr_en && (addr == AW'(i))),
                .wdata    (wdata),
                .ext_in   (ext_clk[i]),
                .ack_clr  (int_ack && grant[i]),
                .cnt_o    (cnt[i]),
                .zc_o     (zc[i]),
                .pend_o   (pend[i]),
                .vec_wr_o (vec_wr[i])
            );
        end
    endgenerate

    ctc_prio #(.N(N_CH), .IW(AW)) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend),
        .grant (grant),
        .idx   (win_idx),
        .any   (any_pend)
    );

    // Vector base register, written only through channel 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (vec_wr[0]) begin
            base_q <= wdata[DW-1:AW+1];
        end
    end

    assign rdata   = cnt[addr];
    assign irq     = any_pend;
    assign int_vec = {base_q, win_idx, 1'b0};

    AST_ACK_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && irq && !(|zc)) |=> ($countones(pend) < $countones($past(pend)))
        || (|zc)); // R11
    AST_BASE_ONLY_CH0: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == AW'(0)) |=> $stable(base_q)); // R2
endmodule

// File: tb/quad_ctc_tb.sv
// Self-checking sweep over channels, prescales, time constants and modes.
module quad_ctc_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [3:0] ext_clk = '0;
    logic [3:0] zc;
    logic       irq;
    logic       int_ack = 1'b0;
    logic [7:0] int_vec;

    int checks = 0;
    int errors = 0;
    int zc_seen [4] = '{0, 0, 0, 0};
    bit done = 1'b0;

    quad_ctc u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ext_clk(ext_clk), .zc(zc), .irq(irq),
        .int_ack(int_ack), .int_vec(int_vec)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        for (int i = 0; i < 4; i++) if (zc[i]) zc_seen[i]++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int ch, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 2'(ch); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk); int_ack = 1'b1;
        @(negedge clk); int_ack = 1'b0;
    endtask

    task automatic pulse(input int ch, input bit lvl);
        ext_clk[ch] = lvl;
        repeat (4) @(negedge clk);
    endtask

    // Timer run: control (stop + tc follows + prescale), then tc.
    task automatic run_timer(input int ch, input bit psel, input int tc);
        int p, t;
        p = psel ? 256 : 16;
        t = (tc == 0) ? 256 : tc;
        wr(ch, 8'h07 | (8'(psel) << 5));
        wr(ch, 8'(tc));
        chk(rdata == 8'(tc), "R4 R12 load", rdata, tc);
        if (t > 1) begin
            repeat (p) @(negedge clk);
            chk(rdata == 8'(t - 1), "R5 R7 first decrement", rdata, t - 1);
            repeat (p * t - 1 - p) @(negedge clk);
        end else begin
            repeat (p - 1) @(negedge clk);
        end
        chk(zc[ch] == 1'b0, "R5 R8 zc before terminal", zc[ch], 0);
        @(negedge clk);
        chk(zc[ch] == 1'b1, "R5 R7 R8 zc at terminal", zc[ch], 1);
        chk(rdata == 8'(tc), "R8 reload", rdata, tc);
        @(negedge clk);
        chk(zc[ch] == 1'b0, "R8 zc one clock", zc[ch], 0);
    endtask

    initial begin
        int n0;
        logic [7:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int c = 0; c < 4; c++) begin
            addr = 2'(c);
            #1 chk(rdata == 8'h00, "R1 count", rdata, 0);
        end
        chk(zc == 4'h0, "R1 zc", zc, 0);
        chk(irq == 1'b0, "R1 irq", irq, 0);
        chk(int_vec == 8'h00, "R1 vector", int_vec, 0);

        // R3: control with tc-follows but no tc, channel must stay idle.
        wr(3, 8'h05);
        repeat (60) @(negedge clk);
        chk(rdata == 8'h00 && zc_seen[3] == 0, "R3 idle without tc", rdata, 0);
        wr(3, 8'h02);

        for (int c = 0; c < 4; c++) begin
            run_timer(c, 1'b0, 1);
            run_timer(c, 1'b0, 3);
            run_timer(c, 1'b0, 0);
        end
        run_timer(0, 1'b1, 2);

        // R10: stop a running channel, its count must hold.
        wr(2, 8'h07);
        wr(2, 8'h05);
        repeat (40) @(negedge clk);
        wr(2, 8'h03);
        addr = 2'd2;
        held = rdata;
        n0 = zc_seen[2];
        repeat (300) @(negedge clk);
        chk(rdata == held, "R10 count holds", rdata, held);
        chk(zc_seen[2] == n0, "R10 no pulses", zc_seen[2], n0);
        for (int c = 0; c < 4; c++) wr(c, 8'h03);

        // R6: counter mode, rising edge, tc 3 on channel 1.
        wr(1, 8'h57);
        wr(1, 8'h03);
        n0 = zc_seen[1];
        for (int k = 1; k <= 2; k++) begin
            pulse(1, 1'b1); pulse(1, 1'b0);
            addr = 2'd1;
            #1 chk(rdata == 8'(3 - k), "R6 rising count", rdata, 3 - k);
        end
        pulse(1, 1'b1); pulse(1, 1'b0);
        chk(rdata == 8'd3, "R6 R8 counter reload", rdata, 3);
        chk(zc_seen[1] == n0 + 1, "R6 R8 counter zc", zc_seen[1], n0 + 1);
        wr(1, 8'h03);

        // R6: falling edge on channel 2; the rising edge is ignored.
        wr(2, 8'h47);
        wr(2, 8'h03);
        pulse(2, 1'b1);
        chk(rdata == 8'd3, "R6 rising ignored", rdata, 3);
        pulse(2, 1'b0);
        chk(rdata == 8'd2, "R6 falling counted", rdata, 2);
        wr(2, 8'h03);

        // R2: vector base via channel 0; a vector on channel 3 is ignored.
        wr(0, 8'hA8);
        wr(3, 8'h50);
        chk(int_vec == 8'hA8, "R2 vector base", int_vec, 8'hA8);

        // R9: terminal counts without interrupt enable raise nothing.
        n0 = zc_seen[3];
        wr(3, 8'h07); wr(3, 8'h01);
        repeat (40) @(negedge clk);
        wr(3, 8'h03);
        chk(zc_seen[3] > n0 && irq == 1'b0, "R9 no irq without enable", irq, 0);

        // R9 R11: channels 1 and 2 with interrupts, then arbitrate.
        wr(2, 8'h87); wr(2, 8'h01);
        wr(1, 8'h87); wr(1, 8'h01);
        repeat (40) @(negedge clk);
        wr(1, 8'h03); wr(2, 8'h03);
        chk(irq == 1'b1, "R9 irq raised", irq, 1);
        chk(int_vec == 8'hAA, "R11 channel 1 wins", int_vec, 8'hAA);
        ack();
        chk(irq == 1'b1 && int_vec == 8'hAC, "R11 channel 2 next", int_vec, 8'hAC);
        ack();
        chk(irq == 1'b0, "R11 all retired", irq, 0);
        done = 1'b1;
    end

    initial begin
        for (int k = 0; k < 150000 && !done; k++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule